// File: doc/BRIEF.md
# Strided Burst DMA Address Generator

This block sequences the addresses and burst sizes for one memory-mapped DMA master. It can serve a read master or a write master. A descriptor is handed in over a valid/ready pair. The descriptor carries a start byte address, a byte length, an 8-bit programmed burst size, a 16-bit stride counted in data words and a sequence tag. While the descriptor is in progress, the block issues a stream of requests over a second valid/ready pair. Each request is a byte address and a beat count.

The programmed burst size is normalised before use. A value of zero selects the instance maximum. Any value above 128 is limited to 128. A stride of one gives contiguous bursts. Any other stride, including zero, which keeps hitting one address, makes the block issue one beat per request, and each request steps the address by stride times the word size. The tag of the descriptor in progress is shown on a status output. A one-cycle pulse marks the end of the work.

The sequencer has three states:
- `ST_IDLE` waits for a descriptor. It goes to `ST_ISSUE` on a descriptor with a nonzero length, or to `ST_FINISH` when the length is zero.
- `ST_ISSUE` presents requests. It moves to `ST_FINISH` when the final request is accepted.
- `ST_FINISH` raises the done pulse and always returns to `ST_IDLE`.

Top module: `stride_burst_agen`

## Requirements
- R1: With stride 1, a programmed burst size from 1 to 128 gives requests of exactly that many beats, except for the final request.
- R2: With stride 1, a programmed burst size of 0 gives requests of `MAX_BURST` beats (default 256), except for the final request.
- R3: With stride 1, a programmed burst size from 129 to 255 gives requests of 128 beats, except for the final request.
- R4: With stride 1, the first request carries the descriptor's start address. Each following request starts at the previous address plus the previous beat count times `DATA_BYTES`.
- R5: The work is ceil(length / `DATA_BYTES`) beats in total. The final request carries only the beats that remain.
- R6: With a stride other than 1, every request has a beat count of 1, and the address steps by stride × `DATA_BYTES` between requests. A stride of 0 keeps the start address on every request.
- R7: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr` and `req_beats` hold their values into the next cycle.
- R8: From the cycle after a descriptor is accepted, `active_seq` shows that descriptor's tag. It holds that value until the next descriptor is accepted.
- R9: `done` is high for exactly one cycle. That cycle comes right after the final request is accepted, or right after acceptance for a zero-length descriptor, which issues no request.
- R10: `desc_ready` is high only when the block is idle. A descriptor offered while the block is busy changes neither the requests nor `active_seq`.
- R11: After reset, `desc_ready` is 1, and `req_valid`, `done` and `active_seq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle and able to take a descriptor |
| desc_addr | input | ADDR_W | Start byte address |
| desc_len | input | LEN_W | Length in bytes |
| desc_burst | input | BCNT_W | Programmed burst size (0 = instance maximum) |
| desc_stride | input | STRIDE_W | Address step in words |
| desc_seq | input | SEQ_W | Descriptor tag |
| req_valid | output | 1 | Request presented |
| req_ready | input | 1 | Request taken |
| req_addr | output | ADDR_W | Request byte address |
| req_beats | output | BEAT_W | Beats in this request |
| active_seq | output | SEQ_W | Tag of the descriptor last accepted |
| done | output | 1 | One-cycle end-of-descriptor pulse |

## Verification
A corrupted remaining-beat count shows up at the ports within one request. Either the final request carries the wrong beat count, or `done` arrives early or late relative to the last handshake. A wrong address register or a wrong stride register is visible on the next request after the first one. A state register stuck in `ST_ISSUE` or `ST_FINISH` shows at once as `desc_ready` staying low, or as `done` lasting more than one cycle. A lost stall hold changes `req_addr` or `req_beats` in the first stalled cycle.

// File: rtl/agen_pkg.sv
package agen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_FINISH = 2'd2
    } agen_state_t;

    localparam int unsigned PROG_CAP = 128;
endpackage

// File: rtl/agen_burst_norm.sv
module agen_burst_norm #(
    parameter int unsigned BCNT_W    = 8,
    parameter int unsigned MAX_BURST = 256,
    parameter int unsigned BEAT_W    = 9
) (
    input  logic [BCNT_W-1:0] prog_burst,
    output logic [BEAT_W-1:0] norm_burst
);
    import agen_pkg::*;

    always_comb begin
        if (prog_burst == '0)
            norm_burst = BEAT_W'(MAX_BURST);
        else if (prog_burst > BCNT_W'(PROG_CAP))
            norm_burst = BEAT_W'(PROG_CAP);
        else
            norm_burst = BEAT_W'(prog_burst);
    end
endmodule

// File: rtl/agen_step.sv
module agen_step #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LEN_W      = 32,
    parameter int unsigned STRIDE_W   = 16,
    parameter int unsigned BEAT_W     = 9,
    parameter int unsigned DATA_BYTES = 4
) (
    input  logic [ADDR_W-1:0]   cur_addr,
    input  logic [LEN_W-1:0]    remain,
    input  logic [BEAT_W-1:0]   burst_n,
    input  logic [STRIDE_W-1:0] stride,
    output logic [BEAT_W-1:0]   beats,
    output logic [ADDR_W-1:0]   next_addr,
    output logic                last
);
    localparam int unsigned LOG_DB = $clog2(DATA_BYTES);

    logic contiguous;
    assign contiguous = (stride == STRIDE_W'(1));

    always_comb begin
        if (contiguous) begin
            beats     = (remain < LEN_W'(burst_n)) ? BEAT_W'(remain) : burst_n;
            next_addr = cur_addr + (ADDR_W'(beats) << LOG_DB);
        end else begin
            beats     = BEAT_W'(1);
            next_addr = cur_addr + (ADDR_W'(stride) << LOG_DB);
        end
        last = (remain == LEN_W'(beats));
    end
endmodule

// File: rtl/stride_burst_agen.sv
module stride_burst_agen #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LEN_W      = 32,
    parameter int unsigned BCNT_W     = 8,
    parameter int unsigned STRIDE_W   = 16,
    parameter int unsigned SEQ_W      = 16,
    parameter int unsigned DATA_BYTES = 4,
    parameter int unsigned MAX_BURST  = 256,
    parameter int unsigned BEAT_W     = $clog2(MAX_BURST + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                desc_valid,
    output logic                desc_ready,
    input  logic [ADDR_W-1:0]   desc_addr,
    input  logic [LEN_W-1:0]    desc_len,
    input  logic [BCNT_W-1:0]   desc_burst,
    input  logic [STRIDE_W-1:0] desc_stride,
    input  logic [SEQ_W-1:0]    desc_seq,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [BEAT_W-1:0]   req_beats,
    output logic [SEQ_W-1:0]    active_seq,
    output logic                done
);
    import agen_pkg::*;

    localparam int unsigned LOG_DB = $clog2(DATA_BYTES);

    agen_state_t state, nxt_state;

    logic [ADDR_W-1:0]   cur_addr;
    logic [LEN_W-1:0]    remain;
    logic [BEAT_W-1:0]   burst_r;
    logic [STRIDE_W-1:0] stride_r;
    logic [SEQ_W-1:0]    seq_r;

    logic [BEAT_W-1:0]   norm_burst;
    logic [BEAT_W-1:0]   step_beats;
    logic [ADDR_W-1:0]   step_next;
    logic                step_last;
    logic [LEN_W:0]      len_round;
    logic [LEN_W-1:0]    total_words;
    logic                take_desc;
    logic                take_req;

    agen_burst_norm #(
        .BCNT_W(BCNT_W), .MAX_BURST(MAX_BURST), .BEAT_W(BEAT_W)
    ) u_norm (
        .prog_burst(desc_burst),
        .norm_burst(norm_burst)
    );

    agen_step #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .STRIDE_W(STRIDE_W),
        .BEAT_W(BEAT_W), .DATA_BYTES(DATA_BYTES)
    ) u_step (
        .cur_addr(cur_addr),
        .remain(remain),
        .burst_n(burst_r),
        .stride(stride_r),
        .beats(step_beats),
        .next_addr(step_next),
        .last(step_last)
    );

    assign len_round   = {1'b0, desc_len} + (LEN_W+1)'(DATA_BYTES - 1);
    assign total_words = LEN_W'(len_round >> LOG_DB);
    assign take_desc   = (state == ST_IDLE) && desc_valid;
    assign take_req    = (state == ST_ISSUE) && req_ready;

    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE:   if (desc_valid)
                           nxt_state = (total_words == '0) ? ST_FINISH : ST_ISSUE;
            ST_ISSUE:  if (req_ready && step_last)
                           nxt_state = ST_FINISH;
            ST_FINISH: nxt_state = ST_IDLE;
            default:   nxt_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt_state;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            remain   <= '0;
            burst_r  <= '0;
            stride_r <= '0;
            seq_r    <= '0;
        end else if (take_desc) begin
            cur_addr <= desc_addr;
            remain   <= total_words;
            burst_r  <= norm_burst;
            stride_r <= desc_stride;
            seq_r    <= desc_seq;
        end else if (take_req) begin
            cur_addr <= step_next;
            remain   <= remain - LEN_W'(step_beats);
        end
    end

    always_comb begin
        desc_ready = (state == ST_IDLE);
        req_valid  = (state == ST_ISSUE);
        done       = (state == ST_FINISH);
        req_addr   = cur_addr;
        req_beats  = step_beats;
        active_seq = seq_r;
    end
endmodule

// File: rtl/stride_burst_agen_chk.sv
module stride_burst_agen_chk #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned STRIDE_W  = 16,
    parameter int unsigned SEQ_W     = 16,
    parameter int unsigned MAX_BURST = 256,
    parameter int unsigned BEAT_W    = 9
) (
    input logic                clk,
    input logic                rst_n,
    input logic                desc_valid,
    input logic                desc_ready,
    input logic [STRIDE_W-1:0] desc_stride,
    input logic                req_valid,
    input logic                req_ready,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [BEAT_W-1:0]   req_beats,
    input logic [SEQ_W-1:0]    active_seq,
    input logic                done
);
    logic [STRIDE_W-1:0] stride_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            stride_q <= STRIDE_W'(1);
        else if (desc_valid && desc_ready)
            stride_q <= desc_stride;
    end

    // R7: request held while stalled
    a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_beats));

    // R6: non-unit stride gives single beats
    a_r6_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && stride_q != STRIDE_W'(1) |-> req_beats == BEAT_W'(1));

    // R6: zero stride keeps the address
    a_r6_zero_stride_addr: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && stride_q == '0 |=> !req_valid || $stable(req_addr));

    // R2: beats never exceed the instance maximum and never drop to zero
    a_r2_beats_range: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_beats != '0 && req_beats <= BEAT_W'(MAX_BURST));

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done never overlaps a request
    a_r9_done_alone: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid && !desc_ready);

    // R10: no request while idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        desc_ready |-> !req_valid);

    // R8: tag only changes across an acceptance
    a_r8_seq_held: assert property (@(posedge clk) disable iff (!rst_n)
        !desc_ready |=> $stable(active_seq));
endmodule

bind stride_burst_agen stride_burst_agen_chk #(
    .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .SEQ_W(SEQ_W),
    .MAX_BURST(MAX_BURST), .BEAT_W(BEAT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_stride(desc_stride), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_beats(req_beats), .active_seq(active_seq),
    .done(done)
);

// File: tb/stride_burst_agen_bench.sv
module stride_burst_agen_bench;
    localparam int ADDR_W = 32, LEN_W = 32, BCNT_W = 8, STRIDE_W = 16, SEQ_W = 16;
    localparam int DB = 4, MAXB = 256, BEAT_W = 9;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] len;
        logic [7:0]  burst;
        logic [15:0] stride;
        logic [15:0] seq;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 32'd64,   8'd4,   16'd1, 16'h0011},
        '{32'h0000_2000, 32'd40,   8'd4,   16'd1, 16'h0012},
        '{32'h0001_0000, 32'd4096, 8'd0,   16'd1, 16'h0013},
        '{32'h0000_3000, 32'd1200, 8'd200, 16'd1, 16'h0014},
        '{32'h0000_4000, 32'd12,   8'd8,   16'd0, 16'h0015},
        '{32'h0000_0100, 32'd16,   8'd8,   16'd2, 16'h0016},
        '{32'h0000_5000, 32'd10,   8'd16,  16'd3, 16'h0017},
        '{32'h0000_6000, 32'd512,  8'd128, 16'd1, 16'h0018},
        '{32'h0000_7000, 32'd0,    8'd4,   16'd1, 16'h0019}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic desc_valid = 1'b0, req_ready = 1'b0;
    logic [ADDR_W-1:0] desc_addr = '0;
    logic [LEN_W-1:0] desc_len = '0;
    logic [BCNT_W-1:0] desc_burst = '0;
    logic [STRIDE_W-1:0] desc_stride = '0;
    logic [SEQ_W-1:0] desc_seq = '0;
    logic desc_ready, req_valid, done;
    logic [ADDR_W-1:0] req_addr;
    logic [BEAT_W-1:0] req_beats;
    logic [SEQ_W-1:0] active_seq;

    int checks = 0, failures = 0, pat = 0, cyc = 0;

    always #2 clk = ~clk;

    stride_burst_agen u_stride_burst_agen (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_addr(desc_addr), .desc_len(desc_len), .desc_burst(desc_burst),
        .desc_stride(desc_stride), .desc_seq(desc_seq), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_beats(req_beats),
        .active_seq(active_seq), .done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 100000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_desc(input vec_t v);
        longint words, rem;
        int nb, bts, guard;
        logic [31:0] a;
        string btag;
        words = (longint'(v.len) + DB - 1) / DB;
        nb = (v.burst == 0) ? MAXB : ((v.burst > 128) ? 128 : int'(v.burst));
        btag = (v.burst == 0) ? "R2" : ((v.burst > 128) ? "R3" : "R1");
        @(negedge clk);
        desc_addr = v.addr; desc_len = v.len; desc_burst = v.burst;
        desc_stride = v.stride; desc_seq = v.seq; desc_valid = 1'b1;
        @(negedge clk);
        desc_valid = 1'b0;
        chk(active_seq == v.seq, "R8", "active_seq", active_seq, v.seq);
        if (words == 0) begin
            chk(done == 1'b1, "R9", "zero-length done", done, 1);
            chk(req_valid == 1'b0, "R9", "zero-length no request", req_valid, 0);
        end else begin
            rem = words; a = v.addr; guard = 0;
            while (rem > 0 && guard < 5000) begin
                guard++;
                req_ready = (pat % 4) != 3;
                pat++;
                bts = (v.stride == 1) ? ((rem < nb) ? int'(rem) : nb) : 1;
                chk(req_valid == 1'b1, "R4", "req_valid", req_valid, 1);
                chk(req_addr == a, (v.stride == 1) ? "R4" : "R6", "req_addr", req_addr, a);
                chk(int'(req_beats) == bts,
                    (v.stride != 1) ? "R6" : ((rem < nb) ? "R5" : btag),
                    "req_beats", req_beats, bts);
                if (req_valid && req_ready) begin
                    rem = rem - bts;
                    a = (v.stride == 1) ? a + 32'(bts * DB) : a + 32'(v.stride) * DB;
                end
                @(negedge clk);
            end
            chk(done == 1'b1, "R9", "done after final request", done, 1);
            chk(req_valid == 1'b0, "R5", "no request past length", req_valid, 0);
        end
        req_ready = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R9", "done width", done, 0);
        chk(desc_ready == 1'b1, "R10", "idle again", desc_ready, 1);
        chk(active_seq == v.seq, "R8", "seq held after done", active_seq, v.seq);
    endtask

    initial begin
        logic [ADDR_W-1:0] held_addr;
        repeat (3) @(negedge clk);
        chk(desc_ready == 1'b1, "R11", "reset desc_ready", desc_ready, 1);
        chk(req_valid == 1'b0, "R11", "reset req_valid", req_valid, 0);
        chk(done == 1'b0, "R11", "reset done", done, 0);
        chk(active_seq == '0, "R11", "reset active_seq", active_seq, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run_desc(VECS[i]);

        // R10 / R7: a descriptor offered while busy, with the request stalled
        @(negedge clk);
        desc_addr = 32'h0000_8000; desc_len = 32'd32; desc_burst = 8'd2;
        desc_stride = 16'd1; desc_seq = 16'h0055; desc_valid = 1'b1;
        @(negedge clk);
        held_addr = req_addr;
        desc_addr = 32'h0000_9000; desc_len = 32'd4; desc_seq = 16'h0077;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(desc_ready == 1'b0, "R10", "busy desc_ready", desc_ready, 0);
            chk(active_seq == 16'h0055, "R10", "busy seq kept", active_seq, 16'h0055);
            chk(req_addr == held_addr, "R7", "stalled addr", req_addr, held_addr);
            chk(req_beats == 9'd2, "R7", "stalled beats", req_beats, 2);
        end
        desc_valid = 1'b0;
        req_ready = 1'b1;
        repeat (4) @(negedge clk);
        chk(done == 1'b1, "R9", "done after four bursts", done, 1);
        req_ready = 1'b0;
        @(negedge clk);
        chk(active_seq == 16'h0055, "R10", "late offer ignored", active_seq, 16'h0055);
        chk(desc_ready == 1'b1, "R10", "idle after run", desc_ready, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule